// File: doc/BRIEF.md
# DMA Channel Control and Count Core

This block is the control core of a single DMA channel. It keeps the channel's configuration (enable, transfer direction, circular operation and three interrupt enables) and a remaining-transfer counter. Each time the external datapath finishes one beat, it pulses a done strobe, and the counter steps down by one. When the counter empties, it either stays at zero or refills itself from a shadow copy of the last accepted count, depending on the circular setting.

A small register port lets a CPU program and read back the configuration, the count and three sticky event flags. These flags are transfer complete, half transfer and transfer error. A request/grant pair faces the transfer engine. A grant is given only while the channel is enabled and has work left. An error input records an error flag and switches the channel off. The interrupt line combines each flag with its enable bit.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the configuration, count and flags all read as zero, and irq and xfer_gnt are low.
- R2: Address 0 holds the configuration in bits [5:0]: bit0 enable, bit1 complete-interrupt enable, bit2 half-interrupt enable, bit3 error-interrupt enable, bit4 direction (1 = memory to peripheral), bit5 circular. Higher bits read as zero. xfer_dir follows bit4.
- R3: A write to address 1 loads bits [15:0] into both the count and its shadow copy, but only while enable is 0. While enabled, such writes are ignored. Bits [31:16] of address 1 read as zero.
- R4: xfer_gnt is high exactly when enable is 1, the count is nonzero and xfer_req is high. A zero count blocks the grant even when the channel is enabled.
- R5: A done strobe while enabled with a nonzero count lowers the count by exactly one at the next clock edge.
- R6: With circular off, a count that reaches zero stays at zero, and further done strobes change nothing.
- R7: With circular on, the beat that would take the count to zero instead reloads the shadow value.
- R8: Address 2 bit1 (half flag) is set by the beat after which the count equals the shadow value shifted right by one.
- R9: Address 2 bit0 (complete flag) is set by the beat that empties the count, in both circular and non-circular modes.
- R10: Flags stay set until the matching flag_clr bit is pulsed (bit0 complete, bit1 half, bit2 error). When a set and a clear hit the same flag in the same cycle, the set wins.
- R11: irq is the OR of complete&bit1, half&bit2 and error&bit3.
- R12: xfer_err sets address 2 bit2 and clears the enable bit at the next clock edge. The grant then drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 count, 2 flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| flag_clr | input | 3 | Per-flag clear strobes |
| xfer_req | input | 1 | Transfer request from the engine |
| xfer_done | input | 1 | One beat completed |
| xfer_err | input | 1 | Transfer error event |
| xfer_gnt | output | 1 | Request granted |
| xfer_dir | output | 1 | Direction bit |
| irq | output | 1 | Combined interrupt |

## Verification
The bench writes a count while the channel is enabled and checks that it is refused. A design that did not lock the count would let software corrupt a transfer that is already running. It runs the count down past zero, where a missing hold would wrap the count to 65535, and checks that the grant drops at zero while the channel is still enabled. In circular mode it checks that the count refills from the shadow value and that the complete flag still fires on that beat. It also hits a half-flag set and its clear in the same cycle, where a wrong priority would silently lose the event. It drives an error and checks that the channel stops granting rather than running on.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
    localparam int CFG_W  = 6;
    localparam int NFLAG  = 3;
    localparam int FLG_TC = 0;
    localparam int FLG_HT = 1;
    localparam int FLG_TE = 2;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    typedef struct packed {
        logic circ;
        logic dir;
        logic teie;
        logic htie;
        logic tcie;
        logic en;
    } cfg_t;
endpackage

// File: rtl/dma_chan_cfg.sv
`timescale 1ns/1ps
module dma_chan_cfg
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             err,
    output cfg_t             cfg
);
    typedef struct packed {
        cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cfg = cfg_t'(wdata);
        end
        // an error always wins over a write and drops the enable
        if (err) begin
            st_d.cfg.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;
endmodule

// File: rtl/dma_chan_count.sv
`timescale 1ns/1ps
module dma_chan_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             circ,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             beat,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] shadow,
    output logic             ev_half,
    output logic             ev_full
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] shadow;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] half_mark;

    always_comb begin
        st_d      = st_q;
        cnt_dec   = st_q.cnt - ONE;
        half_mark = st_q.shadow >> 1;
        ev_half   = 1'b0;
        ev_full   = 1'b0;
        if (load && !en) begin
            st_d.cnt    = load_val;
            st_d.shadow = load_val;
        end else if (beat && en && (st_q.cnt != ZERO)) begin
            ev_full = (cnt_dec == ZERO);
            ev_half = (cnt_dec == half_mark);
            if (ev_full && circ) begin
                st_d.cnt = st_q.shadow;
            end else begin
                st_d.cnt = cnt_dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign shadow = st_q.shadow;
endmodule

// File: rtl/dma_chan_flags.sv
`timescale 1ns/1ps
module dma_chan_flags
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] ena,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } st_t;

    st_t              st_d, st_q;
    logic [NFLAG-1:0] irq_term;

    always_comb begin
        st_d = st_q;
        // set has priority over a simultaneous clear
        st_d.flags = (st_q.flags & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_irq
        assign irq_term[g] = st_q.flags[g] & ena[g];
    end

    assign flags = st_q.flags;
    assign irq   = |irq_term;
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic              xfer_req,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              xfer_gnt,
    output logic              xfer_dir,
    output logic              irq
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    cfg_t             cfg;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] shadow_val;
    logic [NFLAG-1:0] flags_val;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_ena;
    logic             ev_half;
    logic             ev_full;
    logic             wr_cfg;
    logic             wr_cnt;
    logic             cnt_live;
    logic             unused_wdata;

    assign wr_cfg       = reg_wr && (reg_addr == ADDR_CFG);
    assign wr_cnt       = reg_wr && (reg_addr == ADDR_CNT);
    assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

    dma_chan_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cfg),
        .wdata (reg_wdata[CFG_W-1:0]),
        .err   (xfer_err),
        .cfg   (cfg)
    );

    dma_chan_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.en),
        .circ     (cfg.circ),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .beat     (xfer_done),
        .cnt      (cnt_val),
        .shadow   (shadow_val),
        .ev_half  (ev_half),
        .ev_full  (ev_full)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[FLG_TC] = ev_full;
        flag_set[FLG_HT] = ev_half;
        flag_set[FLG_TE] = xfer_err;
        flag_ena         = '0;
        flag_ena[FLG_TC] = cfg.tcie;
        flag_ena[FLG_HT] = cfg.htie;
        flag_ena[FLG_TE] = cfg.teie;
    end

    dma_chan_flags i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .ena   (flag_ena),
        .flags (flags_val),
        .irq   (irq)
    );

    assign cnt_live = cfg.en && (cnt_val != ZERO);
    assign xfer_gnt = cnt_live && xfer_req;
    assign xfer_dir = cfg.dir;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG:  reg_rdata[CFG_W-1:0] = cfg;
            ADDR_CNT:  reg_rdata[CNT_W-1:0] = cnt_val;
            ADDR_FLAG: reg_rdata[NFLAG-1:0] = flags_val;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
`timescale 1ns/1ps
module dma_chan_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [2:0]       flag_clr,
    input logic             xfer_done,
    input logic             xfer_err,
    input logic             xfer_gnt,
    input logic             irq,
    input logic [5:0]       cfg_bits,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] shadow,
    input logic [2:0]       flags
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    p_zero_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ZERO) |-> !xfer_gnt);

    p_shadow_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bits[0] |=> $stable(shadow));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[0] && xfer_done && (cnt > ONE)) |=> (cnt == $past(cnt) - ONE));

    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == ZERO) && !(reg_wr && (reg_addr == 2'd1) && !cfg_bits[0])) |=> (cnt == ZERO));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[0] && cfg_bits[5] && xfer_done && (cnt == ONE)) |=> (cnt == $past(shadow)));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~flag_clr)) |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));

    p_err_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> (!cfg_bits[0] && flags[2]));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .flag_clr  (flag_clr),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err),
    .xfer_gnt  (xfer_gnt),
    .irq       (irq),
    .cfg_bits  (cfg),
    .cnt       (cnt_val),
    .shadow    (shadow_val),
    .flags     (flags_val)
);

// File: tb/test_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  flag_clr = '0;
    logic        xfer_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_err = 1'b0;
    logic        xfer_gnt;
    logic        xfer_dir;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flag_clr  (flag_clr),
        .xfer_req  (xfer_req),
        .xfer_done (xfer_done),
        .xfer_err  (xfer_err),
        .xfer_gnt  (xfer_gnt),
        .xfer_dir  (xfer_dir),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input string what, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, what, reg_rdata, exp);
    endtask

    task automatic gnt_chk(input string req, input logic exp);
        xfer_req = 1'b1;
        #1;
        chk(req, "grant", {31'b0, xfer_gnt}, {31'b0, exp});
        xfer_req = 1'b0;
    endtask

    task automatic beat(input logic [2:0] clr);
        @(negedge clk);
        xfer_done = 1'b1; flag_clr = clr;
        @(negedge clk);
        xfer_done = 1'b0; flag_clr = '0;
    endtask

    task automatic clear(input logic [2:0] clr);
        @(negedge clk);
        flag_clr = clr;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1", "config", 2'd0, 32'h0);
        rd_chk("R1", "count", 2'd1, 32'h0);
        rd_chk("R1", "flags", 2'd2, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);
        gnt_chk("R1", 1'b0);
    endtask

    task automatic t_config;
        wr(2'd0, 32'h0000_003E);
        rd_chk("R2", "config all-but-enable", 2'd0, 32'h3E);
        chk("R2", "dir out", {31'b0, xfer_dir}, 32'h1);
        wr(2'd0, 32'hFFFF_FFC6);
        rd_chk("R2", "upper bits zero", 2'd0, 32'h06);
        chk("R2", "dir low", {31'b0, xfer_dir}, 32'h0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_lock;
        wr(2'd1, 32'h0001_0005);
        rd_chk("R3", "count load, upper zero", 2'd1, 32'h5);
        wr(2'd0, 32'h1);
        wr(2'd1, 32'h9);
        rd_chk("R3", "count locked", 2'd1, 32'h5);
        gnt_chk("R4", 1'b1);
        #1;
        chk("R4", "no request no grant", {31'b0, xfer_gnt}, 32'h0);
    endtask

    task automatic t_linear;
        beat(3'b000);
        rd_chk("R5", "5->4", 2'd1, 32'h4);
        beat(3'b000);
        rd_chk("R5", "4->3", 2'd1, 32'h3);
        rd_chk("R8", "no half yet", 2'd2, 32'h0);
        beat(3'b000);
        rd_chk("R8", "half at 2", 2'd2, 32'h2);
        beat(3'b000);
        beat(3'b000);
        rd_chk("R9", "count empty", 2'd1, 32'h0);
        rd_chk("R9", "complete flag", 2'd2, 32'h3);
        gnt_chk("R4", 1'b0);
        beat(3'b000);
        rd_chk("R6", "zero held", 2'd1, 32'h0);
        chk("R11", "irq off without enables", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h3);
        chk("R11", "irq via complete enable", {31'b0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        rd_chk("R10", "flags sticky", 2'd2, 32'h3);
        clear(3'b011);
        rd_chk("R10", "flags cleared", 2'd2, 32'h0);
        chk("R11", "irq dropped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_circular;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h4);
        wr(2'd0, 32'h25);
        beat(3'b000);
        beat(3'b000);
        rd_chk("R8", "circular half", 2'd2, 32'h2);
        chk("R11", "irq via half enable", {31'b0, irq}, 32'h1);
        clear(3'b010);
        beat(3'b000);
        beat(3'b000);
        rd_chk("R7", "reloaded", 2'd1, 32'h4);
        rd_chk("R9", "complete in circular", 2'd2, 32'h1);
        gnt_chk("R7", 1'b1);
        beat(3'b000);
        beat(3'b010);
        rd_chk("R10", "set beats clear", 2'd2, 32'h3);
        clear(3'b111);
    endtask

    task automatic t_error;
        wr(2'd0, 32'h09);
        gnt_chk("R12", 1'b1);
        @(negedge clk);
        xfer_err = 1'b1;
        @(negedge clk);
        xfer_err = 1'b0;
        rd_chk("R12", "enable dropped", 2'd0, 32'h08);
        rd_chk("R12", "error flag", 2'd2, 32'h4);
        chk("R11", "irq via error enable", {31'b0, irq}, 32'h1);
        gnt_chk("R12", 1'b0);
        wr(2'd1, 32'h7);
        rd_chk("R3", "write after disable", 2'd1, 32'h7);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_lock;
        t_linear;
        t_circular;
        t_error;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule